// File: doc/BRIEF.md
# SD command completion status checker

This block follows a single SD host command from issue to verdict. It has two sticky status registers. The normal register records command-complete and transfer-complete. The error register holds ten separate error conditions. The block runs a small wait sequence over these registers and ends with a one-cycle done pulse, a two-bit outcome code and a request to soft-reset the command and data lines.

Each status bit is set by an event pulse, but only while that bit's status enable is high. Writing a one to the bit's clear input removes it. A second mask selects which latched bits drive the interrupt output. A command first waits for command-complete. If it carries a data phase or expects a busy-type response, it then waits for transfer-complete as well. Any latched error ends either wait early. Each wait is bounded by a programmable cycle limit.

When the sequence finishes, the outcome code is computed from the latched bits. Transfer-complete takes precedence over a data timeout. A data timeout on its own is reported separately from other errors.

Top module: `sd_cmd_verdict`

## Requirements
- R1: After `cmd_start` is accepted in idle, a command with neither data phase nor busy response finishes when command-complete is latched, with outcome code 0 (success) when no error bit is latched.
- R2: When `cmd_has_data` or `cmd_busy_resp` is high at start, the sequence also waits for transfer-complete after command-complete, and finishes only once that is latched.
- R3: Error bit positions are: 0 data timeout, 1 data CRC, 2 data end bit, 3 command timeout, 4 command CRC, 5 command index, 6 command end bit, 7 descriptor DMA fault, 8 auto-stop command fault, 9 current limit. `norm_status` bit 0 is command-complete, bit 1 is transfer-complete, and bit 2 is the OR of all latched error bits whose status enable is set. Any such error ends the wait in progress.
- R4: If transfer-complete and data timeout are both latched when the sequence finishes, the outcome is 0 (success), whatever other errors are present.
- R5: A data timeout without transfer-complete gives outcome 2. Any other latched error gives outcome 1.
- R6: `line_reset_req` pulses together with `seq_done` when the outcome is not 0, when any enabled error is latched, or when the command had a data phase. Otherwise it stays low.
- R7: A one on a bit of `w1c_norm` or `w1c_err` clears that status bit on the next edge. An event on the same bit in the same cycle wins, and the bit stays set.
- R8: An event whose status-enable bit is low does not latch. A command-complete that is not latched therefore cannot end the wait.
- R9: `irq` is high one cycle after any latched normal bit (0 or 1) or error bit is set together with its signal-enable bit. Otherwise it is low.
- R10: If a wait is not satisfied, outcome 3 is reported. With only the command wait, `seq_done` rises on the `wait_limit`+1-th edge after the start edge. When command-complete arrives on the first edge and transfer-complete never does, it rises on the `wait_limit`+3-th edge.
- R11: Accepting `cmd_start` clears every status bit that no event sets in that same cycle.
- R12: After reset all outputs are zero. `seq_done` is a one-cycle pulse, and `seq_result` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Begin a command sequence (accepted in idle) |
| cmd_has_data | input | 1 | Command carries a data phase |
| cmd_busy_resp | input | 1 | Command expects a busy-type response |
| wait_limit | input | WAIT_W | Cycle limit for each wait |
| ev_cmd_done | input | 1 | Command-complete event pulse |
| ev_xfer_done | input | 1 | Transfer-complete event pulse |
| ev_err | input | ERR_W | Error event pulses, one per condition |
| stat_en_norm | input | 2 | Status enable for command/transfer complete |
| stat_en_err | input | ERR_W | Status enable per error bit |
| sig_en_norm | input | 2 | Interrupt enable for command/transfer complete |
| sig_en_err | input | ERR_W | Interrupt enable per error bit |
| w1c_norm | input | 2 | Write-one-to-clear for normal bits 0 and 1 |
| w1c_err | input | ERR_W | Write-one-to-clear for error bits |
| norm_status | output | 3 | Normal status: cmd done, xfer done, error summary |
| err_status | output | ERR_W | Latched error status |
| irq | output | 1 | Interrupt request |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_result | output | 2 | Outcome: 0 ok, 1 error, 2 data timeout, 3 wait expired |
| line_reset_req | output | 1 | Soft-reset request for command and data lines |

## Verification
The main function is driven with plain commands, data-phase commands and busy-response commands. Each is tried with no error, with a lone data timeout, with a data timeout plus transfer-complete, with that same pair plus a data CRC error, with command-side errors and with a current-limit error. These patterns separate the success override from the timeout-during-transfer outcome and from the generic error outcome. They also show when the line reset is raised because of data versus because of an error. Commands whose completion never arrives, in either wait, are timed edge by edge against the limit. Disabled status bits, write-one-to-clear against simultaneous events, and the interrupt masks are each exercised in directed steps.

// File: rtl/sd_cmd_verdict_pkg.sv
package sd_cmd_verdict_pkg;

   localparam int unsigned NORM_CMD  = 0;
   localparam int unsigned NORM_XFER = 1;
   localparam int unsigned NORM_ESUM = 2;
   localparam int unsigned NORM_W    = 3;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_ERR     = 2'd1,
      RES_DTO     = 2'd2,
      RES_WAIT_TO = 2'd3
   } res_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WCMD  = 2'd1,
      ST_WXFER = 2'd2
   } seq_st_e;

endpackage

// File: rtl/scv_stat_reg.sv
module scv_stat_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] en_i,
   input  logic [W-1:0] clr_i,
   input  logic         clr_all_i,
   output logic [W-1:0] q_o
);

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (set_i[b] && en_i[b])
            bit_q <= 1'b1;
         else if (clr_i[b] || clr_all_i)
            bit_q <= 1'b0;
      end
      assign q_o[b] = bit_q;
   end

endmodule

// File: rtl/scv_seq.sv
module scv_seq
   import sd_cmd_verdict_pkg::*;
#(
   parameter int unsigned ERR_W   = 10,
   parameter int unsigned WAIT_W  = 16,
   parameter int unsigned DTO_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              data_i,
   input  logic              busy_i,
   input  logic [WAIT_W-1:0] wait_limit_i,
   input  logic              cmd_seen_i,
   input  logic              xfer_seen_i,
   input  logic [ERR_W-1:0]  err_act_i,
   output logic              accept_o,
   output logic              done_o,
   output res_e              result_o,
   output logic              line_rst_o
);

   seq_st_e           st, st_n;
   logic [WAIT_W-1:0] cnt, cnt_n;
   logic              need_q, data_q;
   logic              fin, tmo, err_any, dto;
   res_e              verdict;

   assign err_any  = |err_act_i;
   assign dto      = err_act_i[DTO_BIT];
   assign accept_o = (st == ST_IDLE) && start_i;

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      fin   = 1'b0;
      tmo   = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (start_i) begin
               st_n  = ST_WCMD;
               cnt_n = '0;
            end
         end
         ST_WCMD: begin
            if (err_any)
               fin = 1'b1;
            else if (cmd_seen_i) begin
               if (need_q) begin
                  st_n  = ST_WXFER;
                  cnt_n = '0;
               end else
                  fin = 1'b1;
            end else if (cnt == wait_limit_i)
               tmo = 1'b1;
            else
               cnt_n = cnt + 1'b1;
         end
         ST_WXFER: begin
            if (err_any || xfer_seen_i)
               fin = 1'b1;
            else if (cnt == wait_limit_i)
               tmo = 1'b1;
            else
               cnt_n = cnt + 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase
      if (fin || tmo)
         st_n = ST_IDLE;
   end

   always_comb begin
      if (tmo)
         verdict = RES_WAIT_TO;
      else if (dto && xfer_seen_i)
         verdict = RES_OK;
      else if (err_any)
         verdict = dto ? RES_DTO : RES_ERR;
      else
         verdict = RES_OK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         need_q     <= 1'b0;
         data_q     <= 1'b0;
         done_o     <= 1'b0;
         result_o   <= RES_OK;
         line_rst_o <= 1'b0;
      end else begin
         st         <= st_n;
         cnt        <= cnt_n;
         done_o     <= fin || tmo;
         line_rst_o <= (fin || tmo) && (tmo || err_any || data_q);
         if (accept_o) begin
            need_q <= data_i || busy_i;
            data_q <= data_i;
         end
         if (fin || tmo)
            result_o <= verdict;
      end
   end

endmodule

// File: rtl/sd_cmd_verdict.sv
module sd_cmd_verdict
   import sd_cmd_verdict_pkg::*;
#(
   parameter int unsigned ERR_W   = 10,
   parameter int unsigned WAIT_W  = 16,
   parameter int unsigned DTO_BIT = 0,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_has_data,
   input  logic              cmd_busy_resp,
   input  logic [WAIT_W-1:0] wait_limit,
   input  logic              ev_cmd_done,
   input  logic              ev_xfer_done,
   input  logic [ERR_W-1:0]  ev_err,
   input  logic [1:0]        stat_en_norm,
   input  logic [ERR_W-1:0]  stat_en_err,
   input  logic [1:0]        sig_en_norm,
   input  logic [ERR_W-1:0]  sig_en_err,
   input  logic [1:0]        w1c_norm,
   input  logic [ERR_W-1:0]  w1c_err,
   output logic [2:0]        norm_status,
   output logic [ERR_W-1:0]  err_status,
   output logic              irq,
   output logic              seq_done,
   output logic [1:0]        seq_result,
   output logic              line_reset_req
);

   localparam int unsigned NORM_LATCH_W = NORM_W - 1;

   if (DTO_BIT >= ERR_W) begin : g_bad_dto
      $error("DTO_BIT must index a bit inside the error vector");
   end
   if (WAIT_W < 2) begin : g_bad_wait
      $error("WAIT_W must be at least 2");
   end
   if (NORM_LATCH_W != 2) begin : g_bad_norm
      $error("normal latch width must be 2");
   end

   logic [NORM_LATCH_W-1:0] norm_q;
   logic [ERR_W-1:0]        err_q, err_act;
   logic                    accept, irq_comb;
   res_e                    res;

   scv_stat_reg #(.W(NORM_LATCH_W)) u_norm (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     ({ev_xfer_done, ev_cmd_done}),
      .en_i      (stat_en_norm),
      .clr_i     (w1c_norm),
      .clr_all_i (accept),
      .q_o       (norm_q)
   );

   scv_stat_reg #(.W(ERR_W)) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (ev_err),
      .en_i      (stat_en_err),
      .clr_i     (w1c_err),
      .clr_all_i (accept),
      .q_o       (err_q)
   );

   assign err_act = err_q & stat_en_err;

   scv_seq #(.ERR_W(ERR_W), .WAIT_W(WAIT_W), .DTO_BIT(DTO_BIT)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (cmd_start),
      .data_i       (cmd_has_data),
      .busy_i       (cmd_busy_resp),
      .wait_limit_i (wait_limit),
      .cmd_seen_i   (norm_q[NORM_CMD]),
      .xfer_seen_i  (norm_q[NORM_XFER]),
      .err_act_i    (err_act),
      .accept_o     (accept),
      .done_o       (seq_done),
      .result_o     (res),
      .line_rst_o   (line_reset_req)
   );

   assign seq_result  = res;
   assign norm_status = {|err_act, norm_q};
   assign err_status  = err_q;
   assign irq_comb    = (|(norm_q & sig_en_norm)) || (|(err_q & sig_en_err));

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_comb;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_comb;
   end

endmodule

// File: rtl/scv_chk.sv
module scv_chk #(
   parameter int unsigned ERR_W   = 10,
   parameter int unsigned DTO_BIT = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             seq_done,
   input logic [1:0]       seq_result,
   input logic             line_reset_req,
   input logic [2:0]       norm_status,
   input logic [ERR_W-1:0] err_status,
   input logic [ERR_W-1:0] stat_en_err,
   input logic [ERR_W-1:0] w1c_err,
   input logic [ERR_W-1:0] ev_err
);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R6
   rst_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && seq_result != 2'd0) |-> line_reset_req);

   // R6
   rst_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_reset_req |-> seq_done);

   // R4
   dto_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && $past(norm_status[1]) && $past(err_status[DTO_BIT] && stat_en_err[DTO_BIT]))
      |-> seq_result == 2'd0);

   // R8
   stat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err_status & ~$past(err_status) & ~$past(stat_en_err)) == '0));

   // R7
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((w1c_err & ~ev_err) != '0) |=> ((err_status & $past(w1c_err & ~ev_err)) == '0));

   // R3
   esum_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      norm_status[2] |-> (err_status != '0));

endmodule

bind sd_cmd_verdict scv_chk #(.ERR_W(ERR_W), .DTO_BIT(DTO_BIT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .seq_done       (seq_done),
   .seq_result     (seq_result),
   .line_reset_req (line_reset_req),
   .norm_status    (norm_status),
   .err_status     (err_status),
   .stat_en_err    (stat_en_err),
   .w1c_err        (w1c_err),
   .ev_err         (ev_err)
);

// File: tb/sim_sd_cmd_verdict.sv
module sim_sd_cmd_verdict;

   localparam int ERR_W = 10;
   localparam int WAIT_W = 16;
   localparam int LIMIT = 20;
   localparam int NV = 13;

   // fields: dp, busy, cmd, xfer, xdly[3:0], errs[9:0], res[1:0], rst
   localparam logic [20:0] VECS [NV] = '{
      {1'b0,1'b0,1'b1,1'b0,4'd0,10'h000,2'd0,1'b0},  // R1 plain command
      {1'b1,1'b0,1'b1,1'b1,4'd3,10'h000,2'd0,1'b1},  // R2 data, late xfer
      {1'b0,1'b1,1'b1,1'b1,4'd2,10'h000,2'd0,1'b0},  // R2 busy, late xfer
      {1'b0,1'b1,1'b1,1'b1,4'd0,10'h000,2'd0,1'b0},  // R2 busy, xfer with cmd
      {1'b1,1'b0,1'b1,1'b1,4'd0,10'h001,2'd0,1'b1},  // R4 dto + xfer
      {1'b1,1'b0,1'b1,1'b1,4'd0,10'h003,2'd0,1'b1},  // R4 dto + crc + xfer
      {1'b0,1'b1,1'b1,1'b1,4'd0,10'h001,2'd0,1'b1},  // R4 R6 busy, reset from error
      {1'b1,1'b0,1'b1,1'b0,4'd0,10'h001,2'd2,1'b1},  // R5 dto alone
      {1'b0,1'b0,1'b1,1'b0,4'd0,10'h010,2'd1,1'b1},  // R5 cmd crc
      {1'b1,1'b0,1'b1,1'b0,4'd0,10'h200,2'd1,1'b1},  // R5 current limit
      {1'b0,1'b0,1'b0,1'b0,4'd0,10'h008,2'd1,1'b1},  // R3 cmd timeout ends wait
      {1'b0,1'b1,1'b1,1'b0,4'd0,10'h000,2'd3,1'b1},  // R10 xfer never
      {1'b0,1'b0,1'b0,1'b0,4'd0,10'h000,2'd3,1'b1}   // R10 cmd never
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_start = 1'b0, cmd_has_data = 1'b0, cmd_busy_resp = 1'b0;
   logic [WAIT_W-1:0] wait_limit = WAIT_W'(LIMIT);
   logic              ev_cmd_done = 1'b0, ev_xfer_done = 1'b0;
   logic [ERR_W-1:0]  ev_err = '0;
   logic [1:0]        stat_en_norm = 2'b11;
   logic [ERR_W-1:0]  stat_en_err = '1;
   logic [1:0]        sig_en_norm = 2'b00;
   logic [ERR_W-1:0]  sig_en_err = '0;
   logic [1:0]        w1c_norm = 2'b00;
   logic [ERR_W-1:0]  w1c_err = '0;
   logic [2:0]        norm_status;
   logic [ERR_W-1:0]  err_status;
   logic              irq, seq_done, line_reset_req;
   logic [1:0]        seq_result;

   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   sd_cmd_verdict #(.ERR_W(ERR_W), .WAIT_W(WAIT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_has_data(cmd_has_data),
      .cmd_busy_resp(cmd_busy_resp), .wait_limit(wait_limit), .ev_cmd_done(ev_cmd_done),
      .ev_xfer_done(ev_xfer_done), .ev_err(ev_err), .stat_en_norm(stat_en_norm),
      .stat_en_err(stat_en_err), .sig_en_norm(sig_en_norm), .sig_en_err(sig_en_err),
      .w1c_norm(w1c_norm), .w1c_err(w1c_err), .norm_status(norm_status),
      .err_status(err_status), .irq(irq), .seq_done(seq_done), .seq_result(seq_result),
      .line_reset_req(line_reset_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic go(input logic dp, input logic busy);
      cmd_has_data  = dp;
      cmd_busy_resp = busy;
      cmd_start     = 1'b1;
      @(negedge clk);
      cmd_start     = 1'b0;
   endtask

   task automatic clear_ev();
      ev_cmd_done  = 1'b0;
      ev_xfer_done = 1'b0;
      ev_err       = '0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!seq_done && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 reset norm", 32'(norm_status), 0);
      chk("R12 reset err", 32'(err_status), 0);
      chk("R12 reset done/rst/irq", {29'd0, seq_done, line_reset_req, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VECS[i]) begin
         logic [20:0] v;
         v = VECS[i];
         go(v[20], v[19]);
         ev_cmd_done  = v[18];
         ev_err       = v[12:3];
         ev_xfer_done = v[17] && (v[16:13] == 4'd0);
         for (int k = 1; k <= int'(v[16:13]); k++) begin
            @(negedge clk);
            clear_ev();
            if (k == int'(v[16:13])) ev_xfer_done = 1'b1;
         end
         @(negedge clk);
         clear_ev();
         wait_done(n);
         chk($sformatf("R1 R2 R10 vec%0d done", i), 32'(seq_done), 1);
         chk($sformatf("R4 R5 vec%0d result", i), 32'(seq_result), 32'(v[2:1]));
         chk($sformatf("R6 vec%0d line reset", i), 32'(line_reset_req), 32'(v[0]));
         chk($sformatf("R3 vec%0d err bits", i), 32'(err_status), 32'(v[12:3]));
         chk($sformatf("R3 vec%0d summary", i), 32'(norm_status[2]), 32'(|v[12:3]));
         @(negedge clk);
         // R12 pulse width and held result
         chk($sformatf("R12 vec%0d done low", i), 32'(seq_done), 0);
         chk($sformatf("R12 vec%0d result held", i), 32'(seq_result), 32'(v[2:1]));
      end

      // R10 exact timing, command wait only
      go(1'b0, 1'b0);
      wait_done(n);
      chk("R10 cmd wait edges", 32'(n), 32'(LIMIT + 1));
      chk("R10 cmd wait code", 32'(seq_result), 3);
      @(negedge clk);

      // R10 exact timing, transfer wait
      go(1'b0, 1'b1);
      ev_cmd_done = 1'b1;
      @(negedge clk);
      clear_ev();
      wait_done(n);
      chk("R10 xfer wait edges", 32'(n + 1), 32'(LIMIT + 3));
      chk("R10 xfer wait code", 32'(seq_result), 3);
      @(negedge clk);

      // R8 disabled command-complete cannot end wait
      stat_en_norm = 2'b10;
      go(1'b0, 1'b0);
      ev_cmd_done = 1'b1;
      @(negedge clk);
      clear_ev();
      @(negedge clk);
      chk("R8 cmd bit not latched", 32'(norm_status[0]), 0);
      wait_done(n);
      chk("R8 wait expires", 32'(seq_result), 3);
      stat_en_norm = 2'b11;
      @(negedge clk);

      // R8 disabled error bit does not latch and has no effect
      stat_en_err = 10'h3EF;
      go(1'b0, 1'b0);
      ev_cmd_done = 1'b1;
      ev_err = 10'h010;
      @(negedge clk);
      clear_ev();
      wait_done(n);
      chk("R8 err bit not latched", 32'(err_status), 0);
      chk("R8 result ok", 32'(seq_result), 0);
      chk("R8 no line reset", 32'(line_reset_req), 0);
      stat_en_err = '1;
      @(negedge clk);

      // R7 write-one-to-clear in idle
      ev_err = 10'h0C0;
      ev_xfer_done = 1'b1;
      @(negedge clk);
      clear_ev();
      @(negedge clk);
      chk("R7 latched", 32'(err_status), 32'h0C0);
      w1c_err = 10'h040;
      w1c_norm = 2'b10;
      @(negedge clk);
      w1c_err = '0;
      w1c_norm = 2'b00;
      @(negedge clk);
      chk("R7 err cleared one bit", 32'(err_status), 32'h080);
      chk("R7 norm cleared", 32'(norm_status[1]), 0);
      w1c_err = 10'h080;
      ev_err = 10'h080;
      @(negedge clk);
      w1c_err = '0;
      clear_ev();
      @(negedge clk);
      chk("R7 event wins over clear", 32'(err_status), 32'h080);

      // R9 interrupt masking
      repeat (2) @(negedge clk);
      chk("R9 irq masked", 32'(irq), 0);
      sig_en_err = 10'h040;
      repeat (2) @(negedge clk);
      chk("R9 irq other bit", 32'(irq), 0);
      sig_en_err = 10'h080;
      repeat (2) @(negedge clk);
      chk("R9 irq enabled", 32'(irq), 1);
      sig_en_err = '0;
      ev_cmd_done = 1'b1;
      @(negedge clk);
      clear_ev();
      sig_en_norm = 2'b01;
      repeat (2) @(negedge clk);
      chk("R9 irq from cmd bit", 32'(irq), 1);
      sig_en_norm = 2'b00;

      // R11 start clears status
      go(1'b0, 1'b0);
      chk("R11 err cleared by start", 32'(err_status), 0);
      chk("R11 norm cleared by start", 32'(norm_status), 0);
      ev_cmd_done = 1'b1;
      @(negedge clk);
      clear_ev();
      wait_done(n);
      chk("R1 final ok", 32'(seq_result), 0);
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule